// File: doc/BRIEF.md
# Banked memory mapper register file

This block holds the bank-switching state of a cartridge memory mapper and turns bus addresses into memory offsets. CPU writes with address bit 15 set are decoded into two program bank registers, a program layout mode bit, a two-bit mirroring code and eight character bank registers. On every cycle the block also translates the current CPU address into an offset into program ROM, built from 8 KB banks. In the same cycle it translates the current PPU address into an offset into character memory, built from 1 KB banks.

A static two-bit variant input picks which low CPU address lines form the two register-select bits. A static strap tells the block that character memory is plain writable RAM rather than ROM. All outputs are registered: each translation appears one clock after its address, and uses the register contents from before any write made in that same cycle. ROM sizes are powers of two given as address-width parameters, and every offset wraps modulo that size.

Top module: `bank_mapper_regs`

## Requirements
- R1: After reset the first program bank register is 0, the second is 1, the mode bit is 0, the mirroring code is 0, character register n holds n, and prg_addr, chr_addr and chr_we are 0.
- R2: With the mode bit 0, CPU address bits 14:13 select the window: 0 uses the first program register, 1 the second, 2 the second-to-last 8 KB bank of the ROM and 3 the last bank. The offset is bank*8192 + addr[12:0], modulo 2^PRG_ADDR_W.
- R3: With the mode bit 1, window 0 maps the second-to-last bank, window 1 the first register, window 2 the second register and window 3 the last bank.
- R4: A write to 0x8xxx loads the first program register from data bits 4:0; a write to 0xAxxx loads the second from data bits 4:0.
- R5: Select bit 0 is the OR of address lines 1 and 6 for variant code 0, lines 2 and 0 for code 1, and lines 3 and 1 for code 2. Select bit 1 is the OR of lines 2 and 7, lines 3 and 1, and lines 2 and 0 for those same codes. Code 3 behaves as code 0.
- R6: A write to 0x9xxx with select bit 1 high loads the mode bit from data bit 1. With select bit 1 low it loads the mirroring code from data bits 1:0 (0 vertical, 1 horizontal, 2 single page 0, 3 single page 1).
- R7: With character ROM, PPU address bits 12:10 pick a character register. chr_addr = bank*1024 + ppu_addr[9:0], modulo 2^CHR_ADDR_W.
- R8: A write to 0xB000-0xEFFF targets character register ((addr - 0xB000) >> 11) + select bit 1. Data bits 3:0 replace the register's upper nibble when select bit 0 is 1, and its lower nibble otherwise; the other nibble is kept. A computed index of 8 changes nothing.
- R9: With chr_is_ram high, chr_addr = ppu_addr[12:0] without banking and chr_we follows ppu_wr one cycle later. With chr_is_ram low, chr_we stays 0.
- R10: Writes with address bit 15 clear, and writes to 0xFxxx, change no register.
- R11: Outputs appear one cycle after their inputs. A translation made in the cycle of a register write uses the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant | input | 2 | Static select-line variant code |
| chr_is_ram | input | 1 | Static strap: character memory is RAM |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address, for writes and for translation |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | PPU address |
| ppu_wr | input | 1 | PPU write strobe |
| prg_addr | output | PRG_ADDR_W | Program ROM offset |
| chr_addr | output | CHR_ADDR_W | Character memory offset |
| chr_we | output | 1 | Character RAM write enable |
| mirror | output | 2 | Mirroring code |

## Verification
The CPU address bus carries both the register write and the program translation, so a bank write always collides with a translation of its own window. The bench writes 0x8000 while that same address is translated and expects the old bank in the next cycle and the new bank one cycle later. Character writes are driven while the PPU reads the targeted window. The bench model computes every expectation from the register state as it stood before the edge, so any early forwarding of a write shows up as a mismatch.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int unsigned CHR_REGS = 8;
  localparam int unsigned PRG_BANK_W = 5;
  localparam int unsigned CHR_BANK_W = 8;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_PAGE0 = 2'd2,
    MIR_PAGE1 = 2'd3
  } mirror_e;

  // write regions taken from cpu_addr[14:12]
  localparam logic [2:0] RG_PRG0 = 3'd0;
  localparam logic [2:0] RG_CTRL = 3'd1;
  localparam logic [2:0] RG_PRG1 = 3'd2;
  localparam logic [2:0] RG_CHR_LO = 3'd3;
  localparam logic [2:0] RG_CHR_HI = 3'd6;
endpackage

// File: rtl/mapper_addr_sel.sv
module mapper_addr_sel (
  input  logic [1:0] variant,
  input  logic [7:0] addr_lo,
  output logic       sel0,
  output logic       sel1
);
  always_comb begin
    case (variant)
      2'd1: begin
        sel0 = addr_lo[2] | addr_lo[0];
        sel1 = addr_lo[3] | addr_lo[1];
      end
      2'd2: begin
        sel0 = addr_lo[3] | addr_lo[1];
        sel1 = addr_lo[2] | addr_lo[0];
      end
      default: begin
        sel0 = addr_lo[1] | addr_lo[6];
        sel1 = addr_lo[2] | addr_lo[7];
      end
    endcase
  end
endmodule

// File: rtl/mapper_prg_bank.sv
module mapper_prg_bank
  import mapper_pkg::*;
#(
  parameter int unsigned PRG_ADDR_W = 17
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [2:0]            region,
  input  logic                  sel1,
  input  logic [7:0]            wdata,
  input  logic [14:0]           rd_addr,
  output logic [PRG_ADDR_W-1:0] prg_addr,
  output logic [1:0]            mirror
);
  localparam int unsigned PBW = PRG_ADDR_W - 13;
  localparam int unsigned FULL_W = PRG_BANK_W + 13;

  logic [PRG_BANK_W-1:0] bank0_q, bank1_q;
  logic                  mode_q;
  logic [PRG_ADDR_W-1:0] off_reg0, off_reg1, off_last, off_slast, off_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank0_q <= '0;
      bank1_q <= PRG_BANK_W'(1);
      mode_q  <= 1'b0;
      mirror  <= MIR_VERT;
    end else if (wr_en) begin
      case (region)
        RG_PRG0: bank0_q <= wdata[PRG_BANK_W-1:0];
        RG_PRG1: bank1_q <= wdata[PRG_BANK_W-1:0];
        RG_CTRL: begin
          if (sel1) mode_q <= wdata[1];
          else      mirror <= wdata[1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    off_reg0  = PRG_ADDR_W'({bank0_q, rd_addr[12:0]});
    off_reg1  = PRG_ADDR_W'({bank1_q, rd_addr[12:0]});
    off_last  = {{PBW{1'b1}}, rd_addr[12:0]};
    off_slast = {{(PBW-1){1'b1}}, 1'b0, rd_addr[12:0]};
    case (rd_addr[14:13])
      2'd0:    off_nxt = mode_q ? off_slast : off_reg0;
      2'd1:    off_nxt = mode_q ? off_reg0 : off_reg1;
      2'd2:    off_nxt = mode_q ? off_reg1 : off_slast;
      default: off_nxt = off_last;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prg_addr <= '0;
    else     prg_addr <= off_nxt;
  end

  logic unused_full;
  assign unused_full = (FULL_W == 0);
endmodule

// File: rtl/mapper_chr_bank.sv
module mapper_chr_bank
  import mapper_pkg::*;
#(
  parameter int unsigned CHR_ADDR_W = 17
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [2:0]            region,
  input  logic                  addr11,
  input  logic                  sel0,
  input  logic                  sel1,
  input  logic [3:0]            nibble,
  input  logic                  chr_is_ram,
  input  logic [12:0]           ppu_addr,
  input  logic                  ppu_wr,
  output logic [CHR_ADDR_W-1:0] chr_addr,
  output logic                  chr_we
);
  localparam int unsigned IDX_W = $clog2(CHR_REGS) + 1;

  logic [CHR_BANK_W-1:0] bank_w [CHR_REGS];
  logic                  hit;
  logic [1:0]            rr;
  logic [IDX_W-1:0]      idx;
  logic [CHR_BANK_W-1:0] cur_bank;

  assign hit = wr_en && (region >= RG_CHR_LO) && (region <= RG_CHR_HI);
  assign rr  = 2'(region - RG_CHR_LO);
  assign idx = IDX_W'({rr, addr11}) + IDX_W'(sel1);

  for (genvar g = 0; g < CHR_REGS; g++) begin : g_reg
    logic [CHR_BANK_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= CHR_BANK_W'(g);
      else if (hit && idx == IDX_W'(g)) begin
        if (sel0) q[7:4] <= nibble;
        else      q[3:0] <= nibble;
      end
    end
    assign bank_w[g] = q;
  end

  assign cur_bank = bank_w[ppu_addr[12:10]];

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_addr <= '0;
      chr_we   <= 1'b0;
    end else begin
      chr_addr <= chr_is_ram ? CHR_ADDR_W'(ppu_addr)
                             : CHR_ADDR_W'({cur_bank, ppu_addr[9:0]});
      chr_we   <= chr_is_ram && ppu_wr;
    end
  end
endmodule

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs #(
  parameter int unsigned PRG_ADDR_W = 17,
  parameter int unsigned CHR_ADDR_W = 17
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            variant,
  input  logic                  chr_is_ram,
  input  logic                  cpu_wr,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_wdata,
  input  logic [13:0]           ppu_addr,
  input  logic                  ppu_wr,
  output logic [PRG_ADDR_W-1:0] prg_addr,
  output logic [CHR_ADDR_W-1:0] chr_addr,
  output logic                  chr_we,
  output logic [1:0]            mirror
);
  logic sel0, sel1, wr_en, unused_ppu13;

  assign wr_en = cpu_wr && cpu_addr[15];
  assign unused_ppu13 = ppu_addr[13];

  mapper_addr_sel u_sel (
    .variant (variant),
    .addr_lo (cpu_addr[7:0]),
    .sel0    (sel0),
    .sel1    (sel1)
  );

  mapper_prg_bank #(.PRG_ADDR_W(PRG_ADDR_W)) u_prg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .region   (cpu_addr[14:12]),
    .sel1     (sel1),
    .wdata    (cpu_wdata),
    .rd_addr  (cpu_addr[14:0]),
    .prg_addr (prg_addr),
    .mirror   (mirror)
  );

  mapper_chr_bank #(.CHR_ADDR_W(CHR_ADDR_W)) u_chr (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .region     (cpu_addr[14:12]),
    .addr11     (cpu_addr[11]),
    .sel0       (sel0),
    .sel1       (sel1),
    .nibble     (cpu_wdata[3:0]),
    .chr_is_ram (chr_is_ram),
    .ppu_addr   (ppu_addr[12:0]),
    .ppu_wr     (ppu_wr),
    .chr_addr   (chr_addr),
    .chr_we     (chr_we)
  );
endmodule

// File: rtl/bank_mapper_regs_chk.sv
module bank_mapper_regs_chk #(
  parameter int unsigned PRG_ADDR_W = 17,
  parameter int unsigned CHR_ADDR_W = 17
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  chr_is_ram,
  input logic                  cpu_wr,
  input logic [15:0]           cpu_addr,
  input logic [13:0]           ppu_addr,
  input logic                  ppu_wr,
  input logic [PRG_ADDR_W-1:0] prg_addr,
  input logic [CHR_ADDR_W-1:0] chr_addr,
  input logic                  chr_we,
  input logic [1:0]            mirror
);
  assert_last_bank_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[14:13] == 2'd3) |=> (&prg_addr[PRG_ADDR_W-1:13]));

  assert_prg_offset_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (prg_addr[12:0] == $past(cpu_addr[12:0])));

  assert_chr_offset_R7: assert property (@(posedge clk) disable iff (rst)
    !chr_is_ram |=> (chr_addr[9:0] == $past(ppu_addr[9:0])));

  assert_ram_direct_R9: assert property (@(posedge clk) disable iff (rst)
    chr_is_ram |=> (chr_addr == CHR_ADDR_W'($past(ppu_addr[12:0]))));

  assert_rom_no_we_R9: assert property (@(posedge clk) disable iff (rst)
    !chr_is_ram |=> !chr_we);

  assert_ram_we_R9: assert property (@(posedge clk) disable iff (rst)
    (chr_is_ram && ppu_wr) |=> chr_we);

  assert_mirror_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && cpu_addr[15:12] == 4'h9) |=> $stable(mirror));
endmodule

bind bank_mapper_regs bank_mapper_regs_chk #(
  .PRG_ADDR_W(PRG_ADDR_W),
  .CHR_ADDR_W(CHR_ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chr_is_ram (chr_is_ram),
  .cpu_wr     (cpu_wr),
  .cpu_addr   (cpu_addr),
  .ppu_addr   (ppu_addr),
  .ppu_wr     (ppu_wr),
  .prg_addr   (prg_addr),
  .chr_addr   (chr_addr),
  .chr_we     (chr_we),
  .mirror     (mirror)
);

// File: tb/bank_mapper_regs_tb.sv
`timescale 1ns/1ps
module bank_mapper_regs_tb;
  localparam int PW = 17;
  localparam int CW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    variant = 2'd0;
  logic          chr_is_ram = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [15:0]   cpu_addr = '0;
  logic [7:0]    cpu_wdata = '0;
  logic [13:0]   ppu_addr = '0;
  logic          ppu_wr = 1'b0;
  logic [PW-1:0] prg_addr;
  logic [CW-1:0] chr_addr;
  logic          chr_we;
  logic [1:0]    mirror;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  int m_prg0, m_prg1, m_mode, m_mir;
  int m_chr [8];

  always #4 clk = ~clk;

  bank_mapper_regs #(.PRG_ADDR_W(PW), .CHR_ADDR_W(CW)) u_dut (
    .clk(clk), .rst(rst), .variant(variant), .chr_is_ram(chr_is_ram),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .ppu_addr(ppu_addr), .ppu_wr(ppu_wr), .prg_addr(prg_addr),
    .chr_addr(chr_addr), .chr_we(chr_we), .mirror(mirror)
  );

  task automatic check(input int act, input int exp, input string tag, input string what);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int msel(input int v, input int a);
    int b0, b1;
    if (v == 1) begin
      b0 = ((a >> 2) | a) & 1;
      b1 = ((a >> 3) | (a >> 1)) & 1;
    end else if (v == 2) begin
      b0 = ((a >> 3) | (a >> 1)) & 1;
      b1 = ((a >> 2) | a) & 1;
    end else begin
      b0 = ((a >> 1) | (a >> 6)) & 1;
      b1 = ((a >> 2) | (a >> 7)) & 1;
    end
    return b1 * 2 + b0;
  endfunction

  function automatic int exp_prg(input int a);
    int low, win, bank, size;
    size = 1 << PW;
    low = a & 16'h1FFF;
    win = (a >> 13) & 3;
    if (win == 3) return size - 8192 + low;
    if (m_mode == 0) begin
      if (win == 2) return size - 16384 + low;
      bank = (win == 0) ? m_prg0 : m_prg1;
    end else begin
      if (win == 0) return size - 16384 + low;
      bank = (win == 1) ? m_prg0 : m_prg1;
    end
    return (bank * 8192 + low) % size;
  endfunction

  function automatic int exp_chr(input int p);
    if (chr_is_ram) return p & 16'h1FFF;
    return (m_chr[(p >> 10) & 7] * 1024 + (p & 10'h3FF)) % (1 << CW);
  endfunction

  task automatic model_write(input int a, input int d);
    int s, idx;
    if (a < 16'h8000) return;
    s = msel(variant, a);
    case (a >> 12)
      8: m_prg0 = d & 31;
      9: if (s & 2) m_mode = (d >> 1) & 1; else m_mir = d & 3;
      10: m_prg1 = d & 31;
      11, 12, 13, 14: begin
        idx = ((a - 16'hB000) >> 11) + ((s >> 1) & 1);
        if (idx < 8) begin
          if (s & 1) m_chr[idx] = (m_chr[idx] & 8'h0F) | ((d & 15) << 4);
          else       m_chr[idx] = (m_chr[idx] & 8'hF0) | (d & 15);
        end
      end
      default: ;
    endcase
  endtask

  task automatic step(input bit wr, input int a, input int d, input int p,
                      input bit pw, input string tag);
    int ep, ec, ew;
    string tp, tc;
    tp = (tag != "") ? tag : (m_mode != 0 ? "R3" : "R2");
    tc = (tag != "") ? tag : (chr_is_ram ? "R9" : "R7");
    cpu_wr = wr; cpu_addr = a[15:0]; cpu_wdata = d[7:0];
    ppu_addr = p[13:0]; ppu_wr = pw;
    ep = exp_prg(a);
    ec = exp_chr(p);
    ew = (chr_is_ram && pw) ? 1 : 0;
    @(posedge clk); #1;
    if (wr) model_write(a, d);
    check(int'(prg_addr), ep, tp, "prg_addr");
    check(int'(chr_addr), ec, tc, "chr_addr");
    check(int'(chr_we), ew, (tag != "") ? tag : "R9", "chr_we");
    check(int'(mirror), m_mir, (tag != "") ? tag : "R6", "mirror");
    cpu_wr = 1'b0; ppu_wr = 1'b0;
  endtask

  task automatic do_reset(input int v, input bit ram);
    variant = v[1:0]; chr_is_ram = ram; rst = 1'b1;
    cpu_wr = 1'b0; ppu_wr = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    m_prg0 = 0; m_prg1 = 1; m_mode = 0; m_mir = 0;
    for (int i = 0; i < 8; i++) m_chr[i] = i;
    check(int'(prg_addr), 0, "R1", "reset prg_addr");
    check(int'(chr_addr), 0, "R1", "reset chr_addr");
    check(int'(chr_we), 0, "R1", "reset chr_we");
    check(int'(mirror), 0, "R1", "reset mirror");
    rst = 1'b0;
  endtask

  task automatic rand_run(input int n, input bit ram);
    int a, d, p;
    bit wr, pw;
    for (int i = 0; i < n; i++) begin
      wr = $urandom % 2;
      a = $urandom & 16'hFFFF;
      if (($urandom % 4) != 0) a = a | 16'h8000;
      d = $urandom & 8'hFF;
      p = $urandom & 14'h3FFF;
      pw = ram ? 1'($urandom % 2) : 1'b0;
      step(wr, a, d, p, pw, "");
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    // variant code 0, character ROM
    do_reset(0, 1'b0);
    step(0, 16'h8000, 0, 14'h0C00, 0, "R1");
    step(0, 16'hA004, 0, 14'h1FFF, 0, "R1");
    // R11: write and translate of the same window in one cycle
    step(1, 16'h8000, 8'hE3, 14'h0000, 0, "R11");
    step(0, 16'h8000, 0, 14'h0000, 0, "R4");
    step(1, 16'hA000, 8'h1F, 14'h0000, 0, "R4");
    step(0, 16'hA123, 0, 14'h0000, 0, "R4");
    step(0, 16'hC000, 0, 14'h0400, 0, "R2");
    step(0, 16'hE123, 0, 14'h0800, 0, "R2");
    step(1, 16'h9004, 8'h02, 14'h0000, 0, "R6");
    for (int w = 0; w < 4; w++) step(0, 16'h8000 + w * 16'h2000 + 16'h55, 0, 0, 0, "R3");
    step(1, 16'h9000, 8'h03, 14'h0000, 0, "R6");
    step(0, 16'h8000, 0, 14'h0000, 0, "R6");
    step(1, 16'hB002, 8'h5A, 14'h0010, 0, "R8");
    step(0, 16'h8000, 0, 14'h0010, 0, "R8");
    step(1, 16'hB000, 8'h06, 14'h0010, 0, "R8");
    step(1, 16'hB804, 8'h09, 14'h0C00, 0, "R8");
    step(1, 16'hE804, 8'h07, 14'h1C00, 0, "R8");
    for (int w = 0; w < 8; w++) step(0, 16'hE000, 0, w * 1024 + 3, 0, "R8");
    step(1, 16'h1000, 8'hFF, 14'h0000, 0, "R10");
    step(1, 16'h0000, 8'hFF, 14'h0000, 0, "R10");
    step(1, 16'h7002, 8'hFF, 14'h0000, 0, "R10");
    step(1, 16'hF006, 8'hFF, 14'h0000, 0, "R10");
    step(1, 16'hF000, 8'hFF, 14'h0000, 0, "R10");
    for (int w = 0; w < 4; w++) step(0, 16'h8000 + w * 16'h2000, 0, w * 2048, 0, "R10");
    rand_run(400, 1'b0);
    // variant code 1
    do_reset(1, 1'b0);
    step(1, 16'h9002, 8'h02, 14'h0000, 0, "R5");
    step(0, 16'h8000, 0, 14'h0000, 0, "R5");
    step(1, 16'h9001, 8'h01, 14'h0000, 0, "R5");
    step(1, 16'hC001, 8'h0F, 14'h0800, 0, "R5");
    step(0, 16'h8000, 0, 14'h0800, 0, "R5");
    rand_run(400, 1'b0);
    // variant code 2
    do_reset(2, 1'b0);
    step(1, 16'h9001, 8'h02, 14'h0000, 0, "R5");
    step(1, 16'h9002, 8'h02, 14'h0000, 0, "R5");
    step(0, 16'h8000, 0, 14'h0000, 0, "R5");
    step(1, 16'hD001, 8'h0C, 14'h1400, 0, "R5");
    step(0, 16'h8000, 0, 14'h1400, 0, "R5");
    rand_run(400, 1'b0);
    // variant code 3 behaves as code 0
    do_reset(3, 1'b0);
    rand_run(200, 1'b0);
    // character RAM
    do_reset(0, 1'b1);
    step(0, 16'h8000, 0, 14'h1ABC, 1, "R9");
    step(1, 16'hB002, 8'h0F, 14'h3FFF, 0, "R9");
    step(0, 16'h8000, 0, 14'h0123, 1, "R9");
    rand_run(300, 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule